// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Update Stage

This block sits between a serial front end and a bank of four 16-bit converters. It holds two registers per channel. Decoded writes from the front end land in a channel's staging register. The converter only ever sees the channel's live register, and a copy from staging to live happens only at well-defined moments. Both moments are set by two active-low pins, the frame pin and the load pin. Both pins are asynchronous to the system clock, and the block resynchronises them internally.

The load pin's level at the end of a frame picks the update mode. If the load pin is low when the frame pin rises, only the channel addressed in that frame is copied to its live register. If the load pin is high, the new word stays in staging. A later falling edge of the load pin then copies all four staging registers at once. A load-pin fall that arrives while a frame is still open is remembered and acts on all channels when the frame closes. This lets a host pre-load every channel and then move them together.

Top module: `dac_dbuf_update`

## Requirements
- R1: After reset, every staging register and every live register holds zero, so all four output lanes read 0x0000.
- R2: If the load pin is low when the frame pin rises, the live register of the last channel written in that frame takes its staging value, and the other three lanes keep their values.
- R3: While the frame pin is low, no live register changes. This holds whatever writes arrive during that time.
- R4: If the load pin is high when the frame pin rises, and no load-pin fall happened during the frame, no lane changes at the end of the frame.
- R5: A load-pin falling edge while the frame pin is high copies all four staging registers into their live registers on the same clock edge.
- R6: A load-pin falling edge while the frame pin is low changes nothing until the frame pin rises. At that point all four channels update.
- R7: A write whose 3-bit channel code is 4, 5, 6 or 7 changes no staging register and does not count as an addressed channel. Channel codes 0 to 3 select lanes 0 to 3.
- R8: Several writes to one channel before a transfer leave only the most recent word to be transferred.
- R9: A lane update becomes visible on the third rising clock edge after the pin edge that causes it. Two edges are spent in the synchroniser and one in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Frame pin, low while a serial frame is open (asynchronous) |
| load_n_i | input | 1 | Load pin, active-low update strobe (asynchronous) |
| wr_vld_i | input | 1 | One-cycle strobe for a decoded write, synchronous to clk |
| wr_addr_i | input | 3 | Channel code of the write |
| wr_data_i | input | 16 | Data word of the write |
| dac_code_o | output | 64 | Live register values; lane n is bits [16n+15:16n] |

## Verification
On every cycle, the assertions check that no transfer is issued while a frame is open. They also check that an end-of-frame transfer in the individual mode touches at most one lane. A held frame with no pending fall must issue no transfer, and a load fall outside a frame or a deferred fall must move all lanes. A live register may change only when a transfer is issued, and a bad channel code must leave the staging registers untouched. Other behaviours can only be shown by the bench's scenarios: which lane ends up with which word, last-write-wins across several frames, the exact three-edge latency from a pin edge, and the deferred all-channel update after a load fall inside a frame.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    localparam int unsigned DEF_NUM_CH  = 4;
    localparam int unsigned DEF_DATA_W  = 16;
    localparam int unsigned DEF_ADDR_W  = 3;
    localparam int unsigned DEF_STAGES  = 2;

    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_ONE  = 2'd1,
        XF_ALL  = 2'd2
    } xfer_kind_e;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        IDLE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic last_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = pin_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.last = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{IDLE}};
            st_q.last <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.pipe[STAGES-1];
    assign last_o = st_q.last;

endmodule

// File: rtl/dac_upd_ctrl.sv
module dac_upd_ctrl
    import dac_upd_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl_i,
    input  logic              frame_last_i,
    input  logic              load_lvl_i,
    input  logic              load_last_i,
    input  logic              wr_vld_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [NUM_CH-1:0] xfer_o
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic            pend_vld;
        logic [CH_W-1:0] pend_ch;
        logic            defer_all;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    xfer_kind_e  kind;
    logic        frame_rise;
    logic        load_fall;
    logic        addr_ok;

    // frame pin is active low: its rise closes a frame
    assign frame_rise = frame_lvl_i & ~frame_last_i;
    assign load_fall  = ~load_lvl_i & load_last_i;
    assign addr_ok    = (int'(wr_addr_i) < int'(NUM_CH));

    always_comb begin
        st_d = st_q;
        kind = XF_NONE;

        if (load_fall) begin
            if (frame_lvl_i) kind = XF_ALL;
            else             st_d.defer_all = 1'b1;
        end

        if (frame_rise) begin
            if (st_q.defer_all) begin
                kind = XF_ALL;
            end else if (!load_lvl_i && st_q.pend_vld && kind == XF_NONE) begin
                kind = XF_ONE;
            end
            st_d.pend_vld  = 1'b0;
            st_d.defer_all = 1'b0;
        end

        if (wr_vld_i && addr_ok) begin
            st_d.pend_vld = 1'b1;
            st_d.pend_ch  = wr_addr_i[CH_W-1:0];
        end
    end

    always_comb begin
        xfer_o = '0;
        unique case (kind)
            XF_ALL: xfer_o = '1;
            XF_ONE: begin
                for (int i = 0; i < int'(NUM_CH); i++) begin
                    xfer_o[i] = (st_q.pend_ch == CH_W'(i));
                end
            end
            default: xfer_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_QUIET_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_lvl_i |-> (xfer_o == '0));                                   // R3
    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rise && !load_lvl_i && !st_q.defer_all && !load_fall)
            |-> $onehot0(xfer_o));                                          // R2
    AST_HELD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rise && load_lvl_i && !st_q.defer_all) |-> (xfer_o == '0));  // R4
    AST_FALL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && frame_lvl_i) |-> (&xfer_o));                          // R5
    AST_DEFER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rise && st_q.defer_all) |-> (&xfer_o));                      // R6

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
    import dac_upd_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_vld_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [NUM_CH-1:0]        xfer_i,
    output logic [NUM_CH*DATA_W-1:0] live_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] stage;
        logic [NUM_CH-1:0][DATA_W-1:0] live;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < int'(NUM_CH); ch++) begin
            if (wr_vld_i && (wr_addr_i == ADDR_W'(ch))) begin
                st_d.stage[ch] = wr_data_i;
            end
            if (xfer_i[ch]) begin
                st_d.live[ch] = st_q.stage[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_lane
            assign live_o[g*DATA_W +: DATA_W] = st_q.live[g];

            AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !xfer_i[g] |=> $stable(st_q.live[g]));                      // R3
            AST_LIVE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
                xfer_i[g] |=> (st_q.live[g] == $past(st_q.stage[g])));      // R5
        end
    endgenerate

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_i && (int'(wr_addr_i) >= int'(NUM_CH))) |=> $stable(st_q.stage)); // R7

endmodule

// File: rtl/dac_dbuf_update.sv
module dac_dbuf_update
    import dac_upd_pkg::*;
#(
    parameter int unsigned NUM_CH      = DEF_NUM_CH,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = DEF_STAGES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_n_i,
    input  logic                     load_n_i,
    input  logic                     wr_vld_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    output logic [NUM_CH*DATA_W-1:0] dac_code_o
);

    logic              frame_lvl, frame_last;
    logic              load_lvl, load_last;
    logic [NUM_CH-1:0] xfer;

    dac_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_frame_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (frame_n_i),
        .lvl_o  (frame_lvl),
        .last_o (frame_last)
    );

    dac_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_load_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (load_n_i),
        .lvl_o  (load_lvl),
        .last_o (load_last)
    );

    dac_upd_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_lvl_i  (frame_lvl),
        .frame_last_i (frame_last),
        .load_lvl_i   (load_lvl),
        .load_last_i  (load_last),
        .wr_vld_i     (wr_vld_i),
        .wr_addr_i    (wr_addr_i),
        .xfer_o       (xfer)
    );

    dac_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld_i  (wr_vld_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .xfer_i    (xfer),
        .live_o    (dac_code_o)
    );

endmodule

// File: tb/dac_dbuf_update_tb_top.sv
module dac_dbuf_update_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int DW         = 16;
    localparam int WD_CYCLES  = 20000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            frame_n;
    logic            load_n;
    logic            wr_vld;
    logic [2:0]      wr_addr;
    logic [DW-1:0]   wr_data;
    logic [NCH*DW-1:0] dac_code;

    int n_run  = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_in  [NCH];
    logic [DW-1:0] exp_out [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dbuf_update dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n_i  (frame_n),
        .load_n_i   (load_n),
        .wr_vld_i   (wr_vld),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .dac_code_o (dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_lane(input string req, input int ch, input logic [DW-1:0] exp);
        logic [DW-1:0] act;
        act = dac_code[ch*DW +: DW];
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane%0d actual=%h expected=%h", req, ch, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int ch = 0; ch < NCH; ch++) chk_lane(req, ch, exp_out[ch]);
    endtask

    task automatic write_word(input logic [2:0] addr, input logic [DW-1:0] data);
        wr_vld  = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_vld  = 1'b0;
        if (int'(addr) < NCH) exp_in[addr] = data;
    endtask

    task automatic copy_all();
        for (int ch = 0; ch < NCH; ch++) exp_out[ch] = exp_in[ch];
    endtask

    // one frame with load pin low; checks mid-frame hold and exact latency
    task automatic t_single(input logic [2:0] addr, input logic [DW-1:0] data, input string tag);
        frame_n = 1'b0;
        tick(3);
        write_word(addr, data);
        tick(4);
        chk_all("R3 frame open");
        frame_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R9 before third edge");
        @(posedge clk);
        @(negedge clk);
        if (int'(addr) < NCH) exp_out[addr] = exp_in[addr];
        chk_all(tag);
        tick(2);
    endtask

    // one frame with load pin high: nothing may reach the lanes
    task automatic t_held(input logic [2:0] addr, input logic [DW-1:0] data);
        frame_n = 1'b0;
        tick(2);
        write_word(addr, data);
        tick(2);
        frame_n = 1'b1;
        tick(6);
        chk_all("R4 held frame");
    endtask

    task automatic t_reset();
        rst_n   = 1'b0;
        frame_n = 1'b1;
        load_n  = 1'b1;
        wr_vld  = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            exp_in[ch]  = '0;
            exp_out[ch] = '0;
        end
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk_all("R1 reset");
    endtask

    task automatic t_individual();
        load_n = 1'b0;
        tick(5);
        copy_all();
        t_single(3'd1, 16'h1234, "R2 R9 lane1");
        t_single(3'd0, 16'hA5A5, "R2 lane0");
        t_single(3'd3, 16'hFFFF, "R2 lane3");
        t_single(3'd2, 16'h0001, "R2 lane2");
    endtask

    task automatic t_bad_code();
        t_single(3'd5, 16'hDEAD, "R7 code 5 no lane change");
        t_single(3'd7, 16'hBEEF, "R7 code 7 no lane change");
        load_n = 1'b1;
        tick(5);
        load_n = 1'b0;
        tick(3);
        copy_all();
        chk_all("R7 staging untouched");
    endtask

    task automatic t_deferred();
        load_n = 1'b1;
        tick(4);
        t_held(3'd0, 16'h1111);
        t_held(3'd0, 16'h2222);
        t_held(3'd2, 16'h3333);
        load_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R5 R9 before third edge");
        @(posedge clk);
        @(negedge clk);
        copy_all();
        chk_all("R5 all lanes together");
        chk_lane("R8 last write wins", 0, 16'h2222);
        tick(2);
    endtask

    task automatic t_fall_in_frame();
        load_n = 1'b1;
        tick(4);
        frame_n = 1'b0;
        tick(2);
        write_word(3'd1, 16'h4444);
        tick(1);
        write_word(3'd3, 16'h5555);
        tick(1);
        load_n = 1'b0;
        tick(6);
        chk_all("R6 fall inside frame deferred");
        frame_n = 1'b1;
        tick(3);
        copy_all();
        chk_all("R6 all lanes at frame end");
        chk_lane("R6 non-last lane moved", 1, 16'h4444);
        tick(2);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_individual();
        t_bad_code();
        t_deferred();
        t_fall_in_frame();
        summary();
        $finish;
    end

endmodule